// File: doc/BRIEF.md
# Double-Latched Serial DAC Word Receiver

This block accepts 16-bit serial words destined for a 12-bit digital-to-analog converter and holds them in two register stages. A frame-sync input (active low) opens a frame, and the bits arrive on a data line. The data line is sampled on each falling edge of a serial clock input. After sixteen such edges, the low twelve bits of the word land in an input latch. A separate active-low load input moves the input latch into the DAC latch. Only the DAC latch drives the converter code output.

The serial clock, frame sync, load and data inputs are asynchronous to the block. All four pass through two-flop synchronizers on a fast system clock, and edge detectors then produce single-cycle events. The load input interacts with a frame that is in progress under fixed rules. A load edge that falls inside a frame is ignored. If the load input is low when the sixteenth bit arrives, the new word goes straight into the DAC latch. A one-cycle strobe marks every write of the DAC latch.

Top module: `dual_latch_dac_rx`

## Requirements
- R1: While reset is applied and after it is released, `dac_code` is 0x000 and `dac_upd` is low, until a load event occurs.
- R2: A frame carries 16 bits, most significant first, sampled on falling serial-clock edges while frame sync is low. The first four bits are discarded. Bits 11..0 of the word become the input latch.
- R3: When no frame is in progress, a falling edge on `ld_n` copies the input latch into `dac_code`. A completed frame with `ld_n` high leaves `dac_code` unchanged.
- R4: If `ld_n` is held low from before a frame until the frame ends, `dac_code` takes the new word at the sixteenth falling serial-clock edge.
- R5: A falling edge of `ld_n` during a frame writes nothing. If `ld_n` stays low to the end of the frame, exactly one write of the new word happens at the sixteenth edge.
- R6: If `ld_n` falls during a frame and rises before the frame ends, that frame causes no DAC write. The input latch still receives the word.
- R7: If frame sync rises before sixteen bits have arrived, the frame is aborted. The input latch is unchanged and no DAC write occurs.
- R8: A falling frame sync starts a new frame with the bit count reset, so a full frame sent after an abort is received correctly.
- R9: `dac_upd` is high for exactly one system clock for each write of `dac_code`.
- R10: Serial-clock edges while frame sync is high shift nothing and change neither latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_in | input | 1 | Serial bit clock; data sampled on its falling edge |
| fs_n_in | input | 1 | Frame sync, low while a frame is valid |
| sdata_in | input | 1 | Serial data, most significant bit first |
| ld_n_in | input | 1 | Active-low load control for the DAC latch |
| dac_code | output | 12 | DAC latch contents, two's complement |
| dac_upd | output | 1 | One-cycle strobe on each DAC latch write |

## Verification
The hardest case to produce is a load edge that lands inside a frame, followed either by a rise before the sixteenth serial edge or by holding low past it. From the ports, the two cases differ only in whether a strobe appears and in which word it carries. The bench drives the serial frame bit by bit and can lower or raise the load input before any chosen bit index. It then counts strobes, so an extra write at the load edge shows up as a wrong count. A word that is received but not loaded is later brought out with an idle load pulse.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_e;
endpackage

// File: rtl/dacrx_rst_sync.sv
module dacrx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dacrx_sync_cell.sv
module dacrx_sync_cell #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dacrx_fall_detect.sv
module dacrx_fall_detect #(
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level;
  end

  assign fall = prev_q & ~level;
endmodule

// File: rtl/dacrx_frame_shifter.sv
module dacrx_frame_shifter
  import dacrx_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_fall,
  input  logic                 fs_fall,
  input  logic                 fs_level,
  input  logic                 sdata,
  output logic                 busy,
  output logic                 frame_done,
  output logic [DATA_BITS-1:0] frame_word,
  output logic [DATA_BITS-1:0] in_latch
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  rx_state_e            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [DATA_BITS-1:0] shift_q, shift_d;
  logic [DATA_BITS-1:0] latch_q;
  logic                 shift_en;
  logic                 latch_en;

  assign frame_word = {shift_q[DATA_BITS-2:0], sdata};

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    shift_d    = shift_q;
    shift_en   = 1'b0;
    latch_en   = 1'b0;
    frame_done = 1'b0;
    if (fs_fall) begin
      state_d = RX_SHIFT;
      cnt_d   = '0;
    end else if (state_q == RX_SHIFT) begin
      if (fs_level) begin
        state_d = RX_IDLE;
        cnt_d   = '0;
      end else if (sclk_fall) begin
        shift_en = 1'b1;
        shift_d  = frame_word;
        if (cnt_q == LAST_IDX) begin
          frame_done = 1'b1;
          latch_en   = 1'b1;
          state_d    = RX_IDLE;
          cnt_d      = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shift_q <= '0;
    else if (shift_en) shift_q <= shift_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= frame_word;
  end

  assign busy     = (state_q == RX_SHIFT);
  assign in_latch = latch_q;
endmodule

// File: rtl/dacrx_load_ctrl.sv
module dacrx_load_ctrl #(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_fall,
  input  logic                 ld_level,
  input  logic                 busy,
  input  logic                 frame_done,
  input  logic [DATA_BITS-1:0] frame_word,
  input  logic [DATA_BITS-1:0] in_latch,
  output logic [DATA_BITS-1:0] dac_code,
  output logic                 dac_upd
);
  logic [DATA_BITS-1:0] dac_q, wr_data;
  logic                 upd_q, wr_en;
  logic                 idle_load, frame_load;

  always_comb begin
    frame_load = frame_done & ~ld_level;
    idle_load  = ld_fall & ~busy;
    wr_en      = frame_load | idle_load;
    wr_data    = frame_load ? frame_word : in_latch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dac_q <= '0;
    else if (wr_en) dac_q <= wr_data;
  end

  assign dac_code = dac_q;
  assign dac_upd  = upd_q;
endmodule

// File: rtl/dual_latch_dac_rx.sv
module dual_latch_dac_rx #(
  parameter int FRAME_BITS  = 16,
  parameter int DATA_BITS   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_in,
  input  logic                 fs_n_in,
  input  logic                 sdata_in,
  input  logic                 ld_n_in,
  output logic [DATA_BITS-1:0] dac_code,
  output logic                 dac_upd
);
  localparam int IDX_SCLK = 0;
  localparam int IDX_FS   = 1;
  localparam int IDX_LD   = 2;
  localparam int IDX_DATA = 3;
  localparam int N_IN     = 4;
  localparam int N_EDGE   = 3;

  logic                 rst_sync_n;
  logic [N_IN-1:0]      raw_in, sync_lvl;
  logic [N_EDGE-1:0]    falls;
  logic                 busy, frame_done;
  logic [DATA_BITS-1:0] frame_word, in_latch;

  dacrx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign raw_in = {sdata_in, ld_n_in, fs_n_in, sclk_in};

  dacrx_sync_cell #(
    .WIDTH(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)
  ) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(raw_in), .q(sync_lvl)
  );

  dacrx_fall_detect #(.WIDTH(N_EDGE), .RST_VAL(3'b111)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .level(sync_lvl[N_EDGE-1:0]), .fall(falls)
  );

  dacrx_frame_shifter #(.FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rst_n(rst_sync_n),
    .sclk_fall(falls[IDX_SCLK]), .fs_fall(falls[IDX_FS]),
    .fs_level(sync_lvl[IDX_FS]), .sdata(sync_lvl[IDX_DATA]),
    .busy(busy), .frame_done(frame_done),
    .frame_word(frame_word), .in_latch(in_latch)
  );

  dacrx_load_ctrl #(.DATA_BITS(DATA_BITS)) u_load (
    .clk(clk), .rst_n(rst_sync_n),
    .ld_fall(falls[IDX_LD]), .ld_level(sync_lvl[IDX_LD]),
    .busy(busy), .frame_done(frame_done),
    .frame_word(frame_word), .in_latch(in_latch),
    .dac_code(dac_code), .dac_upd(dac_upd)
  );
endmodule

// File: rtl/dual_latch_dac_rx_checker.sv
module dual_latch_dac_rx_checker #(
  parameter int DATA_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_sync_n,
  input logic [DATA_BITS-1:0] dac_code,
  input logic                 dac_upd,
  input logic                 frame_done,
  input logic                 ld_fall,
  input logic                 ld_level,
  input logic                 busy
);
  // R1: outputs are at their reset values while the internal reset is held
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (dac_code == '0) && !dac_upd);

  // R9: the strobe never lasts two cycles
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dac_upd |=> !dac_upd);

  // R9: the code moves only in a cycle flagged by the strobe
  assert_code_moves_with_strobe_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dac_upd |-> $stable(dac_code));

  // R4: frame end with load held low produces a write
  assert_held_low_update_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_done && !ld_level) |=> dac_upd);

  // R5: a load edge inside a frame that is not its end writes nothing
  assert_busy_edge_ignored_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld_fall && busy && !frame_done) |=> !dac_upd);

  // R6: a frame ending with load high writes nothing
  assert_released_no_update_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_done && ld_level && !ld_fall) |=> !dac_upd);
endmodule

bind dual_latch_dac_rx dual_latch_dac_rx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n),
  .dac_code(dac_code), .dac_upd(dac_upd),
  .frame_done(frame_done), .ld_fall(falls[IDX_LD]),
  .ld_level(sync_lvl[IDX_LD]), .busy(busy)
);

// File: tb/dual_latch_dac_rx_test.sv
`timescale 1ns/1ps
module dual_latch_dac_rx_test;
  localparam int HALF = 4;
  localparam int NONE = 99;

  logic        clk;
  logic        rst_n;
  logic        sclk_in, fs_n_in, sdata_in, ld_n_in;
  logic [11:0] dac_code;
  logic        dac_upd;

  int n_checks = 0;
  int n_fail   = 0;
  int upd_cnt  = 0;
  int upd_run  = 0;
  int upd_max  = 0;
  bit done     = 0;

  dual_latch_dac_rx uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .fs_n_in(fs_n_in),
    .sdata_in(sdata_in), .ld_n_in(ld_n_in), .dac_code(dac_code), .dac_upd(dac_upd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (dac_upd) begin
      upd_cnt++;
      upd_run++;
      if (upd_run > upd_max) upd_max = upd_run;
    end else begin
      upd_run = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ld_lo / ld_hi / abort_at: bit index before which the action happens
  task automatic send_frame(input logic [15:0] w, input int ld_lo,
                            input int ld_hi, input int abort_at);
    bit aborted = 0;
    fs_n_in = 1'b0;
    wait_clk(2 * HALF);
    for (int i = 0; i < 16; i++) begin
      if (!aborted) begin
        if (i == abort_at) begin
          fs_n_in = 1'b1;
          aborted = 1;
        end else begin
          if (i == ld_lo) ld_n_in = 1'b0;
          if (i == ld_hi) ld_n_in = 1'b1;
          sdata_in = w[15-i];
          sclk_in  = 1'b1;
          wait_clk(HALF);
          sclk_in  = 1'b0;
          wait_clk(HALF);
          sclk_in  = 1'b1;
        end
      end
    end
    wait_clk(HALF);
    fs_n_in = 1'b1;
    wait_clk(3 * HALF);
  endtask

  task automatic ld_pulse();
    ld_n_in = 1'b0;
    wait_clk(8);
    ld_n_in = 1'b1;
    wait_clk(8);
  endtask

  task automatic t_reset();
    check("R1 code after reset", dac_code, 12'h000);
    check("R1 no strobe after reset", upd_cnt, 0);
  endtask

  task automatic t_frame_then_load();
    int b = upd_cnt;
    send_frame(16'hF5A3, NONE, NONE, NONE);
    check("R3 frame alone leaves code", dac_code, 12'h000);
    check("R3 frame alone no strobe", upd_cnt - b, 0);
    ld_pulse();
    check("R2 word after idle load", dac_code, 12'h5A3);
    check("R3 one strobe for idle load", upd_cnt - b, 1);
  endtask

  task automatic t_dont_care();
    send_frame(16'hA123, NONE, NONE, NONE);
    ld_pulse();
    check("R2 leading bits discarded", dac_code, 12'h123);
    send_frame(16'h0800, NONE, NONE, NONE);
    ld_pulse();
    check("R2 negative full scale", dac_code, 12'h800);
  endtask

  task automatic t_held_low();
    int b;
    ld_n_in = 1'b0;            // idle fall copies input latch (0x800): one write
    wait_clk(8);
    b = upd_cnt;
    send_frame(16'h0ABC, NONE, NONE, NONE);
    check("R4 held low loads at frame end", dac_code, 12'hABC);
    check("R4 one strobe for held-low frame", upd_cnt - b, 1);
    ld_n_in = 1'b1;
    wait_clk(8);
    check("R4 release writes nothing", upd_cnt - b, 1);
  endtask

  task automatic t_fall_during();
    int b = upd_cnt;
    send_frame(16'h07FF, 5, NONE, NONE);
    check("R5 code at frame end", dac_code, 12'h7FF);
    check("R5 single write for frame", upd_cnt - b, 1);
    ld_n_in = 1'b1;
    wait_clk(8);
  endtask

  task automatic t_fall_and_release();
    int b = upd_cnt;
    send_frame(16'h0777, 3, 10, NONE);
    check("R6 code kept after released load", dac_code, 12'h7FF);
    check("R6 no strobe", upd_cnt - b, 0);
    ld_pulse();
    check("R6 input latch still updated", dac_code, 12'h777);
  endtask

  task automatic t_abort_restart();
    int b = upd_cnt;
    send_frame(16'hFC3C, 2, NONE, 9);
    check("R7 aborted frame no strobe", upd_cnt - b, 0);
    ld_n_in = 1'b1;
    wait_clk(8);
    ld_pulse();
    check("R7 input latch unchanged by abort", dac_code, 12'h777);
    send_frame(16'h0246, NONE, NONE, NONE);
    ld_pulse();
    check("R8 full frame after abort", dac_code, 12'h246);
  endtask

  task automatic t_stray_clock();
    fs_n_in  = 1'b1;
    sdata_in = 1'b1;
    for (int i = 0; i < 20; i++) begin
      sclk_in = 1'b0; wait_clk(HALF);
      sclk_in = 1'b1; wait_clk(HALF);
    end
    ld_pulse();
    check("R10 clocks outside frame ignored", dac_code, 12'h246);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    sclk_in  = 1'b1;
    fs_n_in  = 1'b1;
    sdata_in = 1'b0;
    ld_n_in  = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    t_reset();
    t_frame_then_load();
    t_dont_care();
    t_held_low();
    t_fall_during();
    t_fall_and_release();
    t_abort_restart();
    t_stray_clock();
    check("R9 strobe width one cycle", upd_max, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule